// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block joins four general registers, an address register, a small arithmetic/logic unit and an internal word memory through a single shared bus. Each clock cycle it takes one command. A command names the bus source as a one-hot selection and the bus destinations as a write-enable mask. It can also carry a set of ALU operations, each of which writes a fixed register. The bus is modelled as a decoded multiplexer: every source has its own decoder output and its own per-bit driver, and the drivers are OR-ed together. This is how a tristate bus behaves when exactly one driver is enabled.

The bus may feed several destinations at once, for example a register and the memory word at the address register. It may not carry two sources at once. A command is rejected if it has two bus sources, if it has destinations but no source, or if two writers target the same register. A rejected command leaves every register, the address register and the memory untouched, and raises an error flag for one cycle.

A small sequencer tracks each command. It has three states. ST_IDLE means no command arrived in the last cycle. ST_DONE means the last command was committed. ST_REJECT means the last command was refused. Its transitions are:

- any state goes to ST_IDLE when `cmd_valid` is low;
- any state goes to ST_DONE on a valid command;
- any state goes to ST_REJECT on an invalid command.

The error output is high exactly in ST_REJECT.

Top module: `bus_rt_datapath`

## Requirements
- R1: `bus_out` combinationally shows the one selected source whenever exactly one bit of `src_sel` is set, and shows zero otherwise. It does not depend on `cmd_valid`. The `src_sel` bits are: bit 0 to bit 3 for R1 to R4, bit 4 for the memory word at AR, and bit 5 for `ext_data`.
- R2: On a valid command, every destination whose `dst_we` bit is set loads the bus value at the clock edge, and several destinations may load in the same edge. The `dst_we` bits are: bit 0 to bit 3 for R1 to R4, bit 4 for the memory word at AR, and bit 5 for AR.
- R3: The memory is addressed by the value AR held before the edge. A command with source memory and destination AR loads AR from the word at the old AR.
- R4: ALU bit 0 (add) sets R1 to R1+R2 modulo 16.
- R5: ALU bit 1 (and) sets R3 to R3 AND R4. ALU bit 2 (increment) sets R2 to R2+1 modulo 16, so 1111 wraps to 0000.
- R6: ALU bit 3 (subtract) sets R1 to R1 minus R3 modulo 16, formed as R1 plus the complement of R3 plus one.
- R7: All operands are the values from before the edge. ALU operations may combine with each other and with a bus transfer in one cycle, provided their destinations differ.
- R8: A command with two or more `src_sel` bits set is invalid.
- R9: A command is invalid if it writes one register from two writers (a bus write enable together with an ALU operation, or add together with subtract). It is also invalid if any `dst_we` bit is set while no source is selected.
- R10: An invalid command changes no register, AR or memory word. `xfer_err` is high for exactly the cycle after it. With `cmd_valid` low nothing changes and `xfer_err` is low.
- R11: Reset clears R1 to R4, AR, every memory word and `xfer_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| src_sel | input | 6 | One-hot bus source selection |
| dst_we | input | 6 | Bus destination write enables |
| alu_en | input | 4 | ALU operations: add, and, increment, subtract |
| ext_data | input | 4 | External word offered as a bus source |
| bus_out | output | 4 | Current bus value |
| regs_q | output | 16 | R1 in bits 3:0 up to R4 in bits 15:12 |
| ar_q | output | 4 | Address register |
| xfer_err | output | 1 | Rejected-command flag |

## Verification
`bus_out` is combinational, so the bench checks it a nanosecond after it changes the selection, before the next rising edge. Register, AR and memory updates land on the first rising edge after the command. The error flag is registered by the sequencer on that same edge. The bench drives each command at a falling edge and checks all of these at the following falling edge, half a period after they settled. Memory contents are read back one command later, by loading AR and then selecting the memory as the bus source.

// File: rtl/bus_rt_pkg.sv
package bus_rt_pkg;
    localparam int NREG    = 4;
    localparam int SRC_MEM = NREG;
    localparam int SRC_EXT = NREG + 1;
    localparam int NSRC    = NREG + 2;
    localparam int DST_MEM = NREG;
    localparam int DST_AR  = NREG + 1;
    localparam int NDST    = NREG + 2;
    localparam int OP_ADD  = 0;
    localparam int OP_AND  = 1;
    localparam int OP_INC  = 2;
    localparam int OP_SUB  = 3;
    localparam int NOPS    = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DONE   = 2'd1,
        ST_REJECT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bus_src_decode.sv
module bus_src_decode #(
    parameter int W = 4,
    parameter int N = 6
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] src_flat,
    output logic [W-1:0]   bus
);
    logic         single;
    logic [N-1:0] drv;
    logic [W-1:0] lane [N];

    assign single = ($countones(sel) == 1);

    generate
        for (genvar i = 0; i < N; i++) begin : g_drv
            // one decoder output and one driver per bit of each source
            assign drv[i]  = sel[i] & single;
            assign lane[i] = src_flat[i*W +: W] & {W{drv[i]}};
        end
    endgenerate

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | lane[i];
        end
    end
endmodule

// File: rtl/bus_rt_alu.sv
module bus_rt_alu #(
    parameter int W = 4
) (
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    input  logic [W-1:0] r4,
    output logic [W-1:0] add_res,
    output logic [W-1:0] and_res,
    output logic [W-1:0] inc_res,
    output logic [W-1:0] sub_res
);
    function automatic logic [W-1:0] adder(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic         cin);
        return a + b + W'(cin);
    endfunction

    always_comb begin
        add_res = adder(r1, r2, 1'b0);
        inc_res = adder(r2, '0, 1'b1);
        sub_res = adder(r1, ~r3, 1'b1);
        and_res = r3 & r4;
    end
endmodule

// File: rtl/bus_cmd_fsm.sv
module bus_cmd_fsm
    import bus_rt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [NSRC-1:0] src_sel,
    input  logic [NDST-1:0] dst_we,
    input  logic [NOPS-1:0] alu_en,
    output logic            commit,
    output logic            err
);
    seq_state_t state, state_nxt;
    logic       multi_src, no_src, collide, bad;
    logic [1:0] wr_cnt [NREG];

    function automatic logic [1:0] cnt3(input logic a, input logic b, input logic c);
        return {1'b0, a} + {1'b0, b} + {1'b0, c};
    endfunction

    always_comb begin
        wr_cnt[0] = cnt3(dst_we[0], alu_en[OP_ADD], alu_en[OP_SUB]);
        wr_cnt[1] = cnt3(dst_we[1], alu_en[OP_INC], 1'b0);
        wr_cnt[2] = cnt3(dst_we[2], alu_en[OP_AND], 1'b0);
        wr_cnt[3] = cnt3(dst_we[3], 1'b0, 1'b0);
        collide = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (wr_cnt[i] > 2'd1) collide = 1'b1;
        end
        multi_src = ($countones(src_sel) > 1);
        no_src    = (src_sel == '0) && (dst_we != '0);
        bad       = multi_src | no_src | collide;
    end

    assign commit = cmd_valid & ~bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE, ST_DONE, ST_REJECT: begin
                if (!cmd_valid) state_nxt = ST_IDLE;
                else if (bad)   state_nxt = ST_REJECT;
                else            state_nxt = ST_DONE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_REJECT: err = 1'b1;
            default:   err = 1'b0;
        endcase
    end

    assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $countones(src_sel) > 1) |=> err);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !err);
endmodule

// File: rtl/bus_rt_datapath.sv
module bus_rt_datapath
    import bus_rt_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [NSRC-1:0]        src_sel,
    input  logic [NDST-1:0]        dst_we,
    input  logic [NOPS-1:0]        alu_en,
    input  logic [DATA_W-1:0]      ext_data,
    output logic [DATA_W-1:0]      bus_out,
    output logic [NREG*DATA_W-1:0] regs_q,
    output logic [DATA_W-1:0]      ar_q,
    output logic                   xfer_err
);
    localparam int DEPTH = 1 << DATA_W;

    logic [DATA_W-1:0]      rq    [NREG];
    logic [DATA_W-1:0]      r_nxt [NREG];
    logic [DATA_W-1:0]      mem   [DEPTH];
    logic [NSRC*DATA_W-1:0] src_flat;
    logic [DATA_W-1:0]      add_res, and_res, inc_res, sub_res;
    logic                   commit;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_src
            assign src_flat[i*DATA_W +: DATA_W] = rq[i];
            assign regs_q[i*DATA_W +: DATA_W]   = rq[i];
        end
    endgenerate
    assign src_flat[SRC_MEM*DATA_W +: DATA_W] = mem[ar_q];
    assign src_flat[SRC_EXT*DATA_W +: DATA_W] = ext_data;

    bus_src_decode #(.W(DATA_W), .N(NSRC)) u_dec (
        .sel      (src_sel),
        .src_flat (src_flat),
        .bus      (bus_out)
    );

    bus_rt_alu #(.W(DATA_W)) u_alu (
        .r1      (rq[0]),
        .r2      (rq[1]),
        .r3      (rq[2]),
        .r4      (rq[3]),
        .add_res (add_res),
        .and_res (and_res),
        .inc_res (inc_res),
        .sub_res (sub_res)
    );

    bus_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .src_sel   (src_sel),
        .dst_we    (dst_we),
        .alu_en    (alu_en),
        .commit    (commit),
        .err       (xfer_err)
    );

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            r_nxt[i] = dst_we[i] ? bus_out : rq[i];
        end
        if (alu_en[OP_ADD]) r_nxt[0] = add_res;
        if (alu_en[OP_SUB]) r_nxt[0] = sub_res;
        if (alu_en[OP_INC]) r_nxt[1] = inc_res;
        if (alu_en[OP_AND]) r_nxt[2] = and_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rq[i] <= '0;
            ar_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < NREG; i++) rq[i] <= r_nxt[i];
            if (dst_we[DST_AR]) ar_q <= bus_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit && dst_we[DST_MEM]) begin
            mem[ar_q] <= bus_out;
        end
    end

    assert_ar_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dst_we[DST_AR]) |=> ar_q == $past(bus_out));
    assert_mem_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dst_we[DST_MEM]) |=> mem[$past(ar_q)] == $past(bus_out));
    assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && alu_en[OP_ADD]) |=> rq[0] == $past(DATA_W'(rq[0] + rq[1])));
    assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && alu_en[OP_INC]) |=> rq[1] == $past(DATA_W'(rq[1] + 1'b1)));
    assert_reject_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !commit) |=> (regs_q == $past(regs_q)) && (ar_q == $past(ar_q)));
endmodule

// File: tb/bus_rt_datapath_test.sv
`timescale 1ns/1ps
module bus_rt_datapath_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  src_sel = '0;
    logic [5:0]  dst_we = '0;
    logic [3:0]  alu_en = '0;
    logic [3:0]  ext_data = '0;
    logic [3:0]  bus_out;
    logic [15:0] regs_q;
    logic [3:0]  ar_q;
    logic        xfer_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_rt_datapath uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .src_sel(src_sel),
        .dst_we(dst_we), .alu_en(alu_en), .ext_data(ext_data), .bus_out(bus_out),
        .regs_q(regs_q), .ar_q(ar_q), .xfer_err(xfer_err)
    );

    // {src, dst, alu, din, expected R4..R1, expected AR, expected err}
    localparam int NV = 20;
    localparam logic [40:0] VEC [NV] = '{
        {6'h20, 6'h01, 4'h0, 4'hA, 16'h000A, 4'h0, 1'b0}, // R2 load R1
        {6'h20, 6'h02, 4'h0, 4'h9, 16'h009A, 4'h0, 1'b0},
        {6'h20, 6'h04, 4'h0, 4'hD, 16'h0D9A, 4'h0, 1'b0},
        {6'h20, 6'h08, 4'h0, 4'h6, 16'h6D9A, 4'h0, 1'b0},
        {6'h00, 6'h00, 4'h1, 4'h0, 16'h6D93, 4'h0, 1'b0}, // R4 add
        {6'h00, 6'h00, 4'h6, 4'h0, 16'h64A3, 4'h0, 1'b0}, // R5 R7 and+inc
        {6'h00, 6'h00, 4'h8, 4'h0, 16'h64AF, 4'h0, 1'b0}, // R6 sub
        {6'h01, 6'h12, 4'h0, 4'h0, 16'h64FF, 4'h0, 1'b0}, // R2 fan-out
        {6'h20, 6'h20, 4'h0, 4'h3, 16'h64FF, 4'h3, 1'b0}, // R3 AR load
        {6'h08, 6'h10, 4'h0, 4'h0, 16'h64FF, 4'h3, 1'b0},
        {6'h10, 6'h20, 4'h0, 4'h0, 16'h64FF, 4'h6, 1'b0}, // R3 AR <- M[AR]
        {6'h04, 6'h01, 4'h4, 4'h0, 16'h6404, 4'h6, 1'b0}, // R5 wrap, R7
        {6'h01, 6'h08, 4'h1, 4'h0, 16'h4404, 4'h6, 1'b0}, // R7 old values
        {6'h03, 6'h04, 4'h0, 4'h0, 16'h4404, 4'h6, 1'b1}, // R8
        {6'h01, 6'h01, 4'h1, 4'h0, 16'h4404, 4'h6, 1'b1}, // R9
        {6'h00, 6'h00, 4'h9, 4'h0, 16'h4404, 4'h6, 1'b1}, // R9
        {6'h00, 6'h01, 4'h0, 4'h0, 16'h4404, 4'h6, 1'b1}, // R9
        {6'h20, 6'h02, 4'h0, 4'h7, 16'h4474, 4'h6, 1'b0}, // R10 clears
        {6'h02, 6'h04, 4'h2, 4'h0, 16'h4474, 4'h6, 1'b1}, // R9
        {6'h04, 6'h30, 4'h8, 4'h0, 16'h4470, 4'h4, 1'b0}  // R6 R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] s, input logic [5:0] d,
                         input logic [3:0] a, input logic [3:0] x);
        cmd_valid = v; src_sel = s; dst_we = d; alu_en = a; ext_data = x;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 regs", regs_q, 0);
        check("R11 ar", ar_q, 0);
        check("R11 err", xfer_err, 0);
        check("R1 no source", bus_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][40:35], VEC[i][34:29], VEC[i][28:25], VEC[i][24:21]);
            @(negedge clk);
            check(VEC[i][0] ? "R8 R9 R10 regs" : "R2 R4 R5 R6 R7 regs", regs_q, VEC[i][20:5]);
            check(VEC[i][0] ? "R10 ar" : "R2 R3 ar", ar_q, VEC[i][4:1]);
            check("R10 err flag", xfer_err, VEC[i][0]);
        end
        // R10: no command, nothing changes
        drive(1'b0, 6'h20, 6'h01, 4'h1, 4'hF);
        @(negedge clk);
        check("R10 idle regs", regs_q, 16'h4470);
        check("R10 idle err", xfer_err, 0);
        // R1: combinational bus view
        drive(1'b0, 6'h02, 6'h00, 4'h0, 4'h0);
        #1 check("R1 bus R2", bus_out, 4'h7);
        src_sel = 6'h03;
        #1 check("R1 two sources", bus_out, 4'h0);
        src_sel = 6'h20; ext_data = 4'hC;
        #1 check("R1 ext", bus_out, 4'hC);
        drive(1'b0, 6'h00, 6'h00, 4'h0, 4'h0);
        @(negedge clk);
        // R3 / R2: memory readback through AR
        drive(1'b1, 6'h20, 6'h20, 4'h0, 4'h3);
        @(negedge clk);
        drive(1'b1, 6'h10, 6'h00, 4'h0, 4'h0);
        #1 check("R2 R3 mem[3]", bus_out, 4'h6);
        @(negedge clk);
        drive(1'b1, 6'h20, 6'h20, 4'h0, 4'h0);
        @(negedge clk);
        drive(1'b1, 6'h10, 6'h00, 4'h0, 4'h0);
        #1 check("R2 mem[0]", bus_out, 4'hF);
        @(negedge clk);
        drive(1'b1, 6'h20, 6'h20, 4'h0, 4'h6);
        @(negedge clk);
        drive(1'b1, 6'h10, 6'h00, 4'h0, 4'h0);
        #1 check("R2 mem[6]", bus_out, 4'h4);
        @(negedge clk);
        // R8 rejected memory write leaves memory alone
        drive(1'b1, 6'h11, 6'h10, 4'h0, 4'h0);
        @(negedge clk);
        check("R8 err", xfer_err, 1);
        drive(1'b1, 6'h10, 6'h00, 4'h0, 4'h0);
        #1 check("R10 mem kept", bus_out, 4'h4);
        @(negedge clk);
        check("R10 err one cycle", xfer_err, 0);
        // R11 reset mid-run
        drive(1'b0, 6'h00, 6'h00, 4'h0, 4'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 regs cleared", regs_q, 0);
        check("R11 ar cleared", ar_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 6'h10, 6'h00, 4'h0, 4'h0);
        #1 check("R11 mem cleared", bus_out, 0);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule